// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit operand by an amount that comes from the low byte of a register. It also produces the new carry flag that a processor would store for a flag-setting shift. The caller picks one of four operations: logical left, logical right, arithmetic right or rotate right. It supplies the operand, the 8-bit amount and the carry flag currently held. The block returns the shifted value and the updated carry.

Amounts of 32 and more have their own result and carry for each operation, and they are not folded back into the 0 to 31 range. Rotate is the exception, because it takes the amount modulo 32. An amount of zero hands the operand and the incoming carry straight through. The datapath is combinational. A parameter adds one output register stage, and a valid bit travels alongside the data.

Top module: `regshift_carry`

## Requirements
- R1: The whole 8-bit amount is used (0 to 255). Amounts of 64 and above, up to 255, give the same outcome as any other amount above 32 for the shift operations. For rotate they reduce modulo 32.
- R2: When the amount is 0, result equals the operand and carry_out equals carry_in, for every op code.
- R3: op = 2'b00 selects logical left. For amounts 1 to 31, zeros fill from bit 0 and carry = operand[32 - amount]. For amount 32, result = 0 and carry = operand[0]. For amounts above 32, result = 0 and carry = 0.
- R4: op = 2'b01 selects logical right. For amounts 1 to 31, zeros fill from bit 31 and carry = operand[amount - 1]. For amount 32, result = 0 and carry = operand[31]. For amounts above 32, result = 0 and carry = 0.
- R5: op = 2'b10 selects arithmetic right. For amounts 1 to 31, copies of operand[31] fill from the top and carry = operand[amount - 1]. For amounts of 32 and above, every result bit and the carry equal operand[31].
- R6: op = 2'b11 selects rotate right by amount mod 32. If that remainder is r > 0, carry = operand[r - 1]. If r = 0 and the amount is non-zero, result = operand and carry = operand[31].
- R7: With REG_OUT = 1, out_valid, result and carry_out appear one clock after in_valid and the inputs. Reset drives all three to 0. With REG_OUT = 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks the inputs as a request |
| op | input | 2 | Operation select: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| operand | input | 32 | Value to shift |
| amount | input | 8 | Shift amount, the low byte of a register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Marks result and carry_out as valid |
| result | output | 32 | Shifted or rotated value |
| carry_out | output | 1 | New carry flag |

## Verification
Most faults in the range decode show up only at a few amounts. If the edge at 32 is decoded wrongly, a logical shift by exactly 32 returns the wrong carry or a non-zero value. If rotate folds the amount the wrong way, an amount of 32 or 64 gives a wrong carry. If the carry bypass is broken, it is visible only at amount 0. Each of these appears at the ports on the very next valid output. The bench therefore compares every operation at the amounts 0, 1, 31, 32, 33 and 255, and at a spread of other amounts, against an independent 64-bit reference model.

// File: rtl/regshift_carry.sv
module regshift_carry #(
  parameter int WIDTH   = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] amount,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int SW = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] AMT_EDGE = AMT_W'(WIDTH);

  logic [SW-1:0]      sh, up_idx, dn_idx;
  logic               amt_zero, amt_edge, amt_over, amt_under;
  logic [2*WIDTH-1:0] rot_dbl;
  logic [WIDTH-1:0]   nres;
  logic               ncar;

  assign sh        = amount[SW-1:0];
  assign up_idx    = sh - 1'b1;
  assign dn_idx    = '0 - sh;
  assign amt_zero  = (amount == '0);
  assign amt_edge  = (amount == AMT_EDGE);
  assign amt_over  = (amount > AMT_EDGE);
  assign amt_under = !amt_edge && !amt_over;
  assign rot_dbl   = {operand, operand} >> sh;

  always_comb begin
    nres = operand;
    ncar = carry_in;
    if (!amt_zero) begin
      case (op)
        2'b00: begin
          if (amt_under) begin
            nres = operand << sh;
            ncar = operand[dn_idx];
          end else begin
            nres = '0;
            ncar = amt_edge ? operand[0] : 1'b0;
          end
        end
        2'b01: begin
          if (amt_under) begin
            nres = operand >> sh;
            ncar = operand[up_idx];
          end else begin
            nres = '0;
            ncar = amt_edge ? operand[WIDTH-1] : 1'b0;
          end
        end
        2'b10: begin
          if (amt_under) begin
            nres = WIDTH'($signed(operand) >>> sh);
            ncar = operand[up_idx];
          end else begin
            nres = {WIDTH{operand[WIDTH-1]}};
            ncar = operand[WIDTH-1];
          end
        end
        default: begin
          if (sh == '0) begin
            nres = operand;
            ncar = operand[WIDTH-1];
          end else begin
            nres = rot_dbl[WIDTH-1:0];
            ncar = operand[up_idx];
          end
        end
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= '0;
          carry_out <= 1'b0;
        end else begin
          out_valid <= in_valid;
          result    <= nres;
          carry_out <= ncar;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = nres;
      assign carry_out = ncar;
    end
  endgenerate
endmodule

// File: rtl/regshift_carry_chk.sv
module regshift_carry_chk #(
  parameter int WIDTH   = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op,
  input logic [WIDTH-1:0] operand,
  input logic [AMT_W-1:0] amount,
  input logic             carry_in,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  localparam int SW = $clog2(WIDTH);

  generate
    if (REG_OUT) begin : g_seq
      a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
      a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amount == '0) |=> (result == $past(operand) && carry_out == $past(carry_in)));
      a_r3_left_over: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && amount > AMT_W'(WIDTH)) |=> (result == '0 && !carry_out));
      a_r4_right_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01 && amount == AMT_W'(WIDTH)) |=> (result == '0 && carry_out == $past(operand[WIDTH-1])));
      a_r5_arith_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10 && amount >= AMT_W'(WIDTH)) |=> (result == {WIDTH{$past(operand[WIDTH-1])}} && carry_out == $past(operand[WIDTH-1])));
      a_r6_rotate_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11 && amount != '0 && amount[SW-1:0] == '0) |=> (result == $past(operand) && carry_out == $past(operand[WIDTH-1])));
    end
  endgenerate
endmodule

bind regshift_carry regshift_carry_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/regshift_carry_test.sv
module regshift_carry_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [31:0] operand = '0;
  logic [7:0]  amount = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  regshift_carry uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
    .amount(amount), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .carry_out(carry_out)
  );

  function automatic logic [32:0] model(input logic [1:0] o, input logic [31:0] v,
                                        input logic [7:0] a, input logic c);
    logic [63:0] t;
    logic [4:0]  r;
    if (a == 0) return {c, v};
    case (o)
      2'b00: begin t = {32'b0, v} << a; return {t[32], t[31:0]}; end
      2'b01: begin t = {v, 32'b0} >> a; return {t[31], t[63:32]}; end
      2'b10: begin
        t = 64'($signed({v, 32'b0}) >>> ((a > 8'd63) ? 8'd63 : a));
        return {t[31], t[63:32]};
      end
      default: begin
        r = a[4:0];
        if (r == 0) return {v[31], v};
        t = {v, v} >> r;
        return {t[31], t[31:0]};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic [7:0] a);
    if (a == 0) return "R2";
    if (a >= 8'd64) return "R1";
    case (o)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [1:0] o, input logic [31:0] v,
                       input logic [7:0] a, input logic c);
    @(negedge clk);
    in_valid = 1'b1; op = o; operand = v; amount = a; carry_in = c;
    exp_q.push_back(model(o, v, a, c));
    tag_q.push_back(tag_of(o, a));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected out_valid: actual=1 expected=0");
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({carry_out, result} !== e) begin
          failures++;
          $display("FAIL %s actual carry=%0b result=%h expected carry=%0b result=%h",
                   t, carry_out, result, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals[3];
    logic [7:0]  amts[6];
    logic [31:0] lfsr;
    vals = '{32'h8000_0001, 32'h7FFF_0000, 32'hA5A5_3C3C};
    amts = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};

    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0) begin
      failures++;
      $display("FAIL R7 reset state actual v=%0b r=%h c=%0b expected 0 0 0",
               out_valid, result, carry_out);
    end
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++)
      for (int vi = 0; vi < 3; vi++)
        for (int ai = 0; ai < 6; ai++)
          for (int c = 0; c < 2; c++)
            drive(2'(o), vals[vi], amts[ai], 1'(c));

    idle();
    checks++;
    @(negedge clk);
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R7 out_valid after idle actual=%0b expected=0", out_valid);
    end

    for (int o = 0; o < 4; o++)
      for (int a = 2; a < 256; a += 13)
        drive(2'(o), 32'hC001_D00D ^ 32'(a * 32'h0101_0101), 8'(a), 1'(a & 1));
    drive(2'b00, 32'hFFFF_FFFF, 8'd64, 1'b1);
    drive(2'b11, 32'h1234_5678, 8'd64, 1'b0);
    drive(2'b11, 32'h1234_5678, 8'd96, 1'b1);
    drive(2'b10, 32'h0000_0001, 8'd200, 1'b1);

    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[9:8], lfsr ^ 32'h5A5A_0F0F, lfsr[7:0], lfsr[10]);
    end
    idle();
    repeat (3) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R7 missing outputs actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule